// File: doc/BRIEF.md
# Power Event SMI/SCI Router

This block collects power-management events from around the chip and turns them into two interrupt requests: a level-sensitive SCI for the operating system and an SMI for firmware. The events are GPIO inputs from the core and suspend wells, four PCIe wake pins, a PCIe SMI message, a rising edge on a USB write-enable signal, a power-button override, a firmware release write, and a synchronous SMI request. Each event sets a sticky status bit. Software clears a status bit by writing 1 to it.

Most status bits latch whether or not their enables are set. GPIO status bits are the exception. A GPIO status bit latches only when the GPIO's two-bit route field selects that path and the path's per-GPIO enable is set. Two control bits then decide which interrupt leaves the block: an SCI enable and a global SMI enable. The firmware-release status is special and raises SCI even when SCI is disabled.

A synchronous SMI request holds back its completion pulse until a separate acknowledge input arrives. All registers are reached through a simple word-wide read/write port. Reads return data one cycle after the request.

Top module: `pm_event_router`

## Requirements
- R1: Non-GPIO status bits (PCIe SMI, wake, USB, power-button override, release, sync SMI) latch on their event regardless of any enable. In the status register at address 1 they sit at: bit 0 PCIe SMI, bits 4:1 wake 3:0, bit 5 USB, bit 6 power-button override, bit 7 release, bit 8 sync SMI.
- R2: The route field of GPIO j occupies bits [2j+1:2j] of address 5. Core GPIO i is j=i and suspend GPIO i is j=8+i. A route value of 10b selects SCI and 01b selects SMI. A GPIO status bit latches only when the route selects its path and that path's enable for the GPIO is 1. Route values 00b and 11b latch nothing.
- R3: At address 2 (SCI GPIO status) and address 3 (SCI GPIO enable), bits 31:24 are core GPIO 7:0 and bits 23:16 are suspend GPIO 7:0. At address 4, bits 31:24 and 23:16 are the SMI status bits for core and suspend GPIO, and bits 15:8 and 7:0 are the matching SMI enables.
- R4: Control register (address 0): bit 0 SCI enable, bit 1 global SMI enable, bit 2 USB SMI enable, bit 3 USB local enable, bits 7:4 wake enables 3:0. A set wake status raises SCI only when its wake enable and SCI enable are both 1.
- R5: Writing 1 to bit 0 of address 6 sets the release status. While the release status is set, SCI is raised even when SCI enable is 0.
- R6: A power-button override pulse produces a one-cycle off request on the following cycle. Its status bit persists. SCI follows when SCI enable is later set, unless the status was cleared first.
- R7: A synchronous SMI request produces no completion until the acknowledge input is seen. The completion is a one-cycle pulse in the cycle after the acknowledge. An acknowledge with no request pending produces nothing.
- R8: Only a 0-to-1 transition of the USB write-enable input sets the USB status. A held high level does not set it again. USB raises SMI only when both the USB local enable and the USB SMI enable are 1.
- R9: A PCIe SMI message sets its status and raises SMI with no local enable in this block.
- R10: SMI is asserted only while the global SMI enable is 1 and an enabled SMI-routed status is set.
- R11: Writing 1 clears a status bit. If an event arrives in the same cycle as the clear, the status stays set.
- R12: After reset, every register reads 0 and sci_o, smi_o, off_req_o and ssmi_cpl_o are low.
- R13: Interrupt outputs are registered. They follow a status or control change one cycle after that change takes effect. Read data appears one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| gpio_core_i | input | 8 | Core-well GPIO event pulses |
| gpio_sus_i | input | 8 | Suspend-well GPIO event pulses |
| wake_i | input | 4 | PCIe wake event pulses |
| pcie_smi_i | input | 1 | PCIe SMI message pulse |
| usb_we_i | input | 1 | USB per-port write-enable level |
| pwrbtn_or_i | input | 1 | Power-button override pulse |
| ssmi_req_i | input | 1 | Synchronous SMI request pulse |
| ssmi_ack_i | input | 1 | Synchronous SMI acknowledge pulse |
| sci_o | output | 1 | Level SCI request |
| smi_o | output | 1 | Level SMI request |
| off_req_o | output | 1 | Request to go to the off state |
| ssmi_cpl_o | output | 1 | Synchronous SMI completion pulse |

## Verification
The routing logic is driven with GPIO pulses under each route value: SCI-routed, SMI-routed, none and reserved. Each is tried with the per-path enable both on and off, so the test separates "latched but not signalled" from "never latched". Wake and USB events are raised with their enables off first and then switched on. This shows that status capture does not depend on the enables while the interrupt outputs do. The release, power-button and sync-SMI cases check SCI forcing with SCI disabled, persistence until software clears the bit, and withheld completion. A write-one-to-clear that lands in the same cycle as a new event shows which of the two wins.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_t;

  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL    = 3'd0;
  localparam logic [AW-1:0] A_FIXSTS  = 3'd1;
  localparam logic [AW-1:0] A_SCISTS  = 3'd2;
  localparam logic [AW-1:0] A_SCIEN   = 3'd3;
  localparam logic [AW-1:0] A_SMIGPIO = 3'd4;
  localparam logic [AW-1:0] A_ROUTE   = 3'd5;
  localparam logic [AW-1:0] A_RELEASE = 3'd6;

  // bit position of GPIO j's status (both paths) and SCI enable
  function automatic int gpio_sts_pos(input int j, input int ng);
    return (j < ng) ? 24 + j : 16 + j - ng;
  endfunction

  // bit position of GPIO j's SMI enable
  function automatic int gpio_smien_pos(input int j, input int ng);
    return (j < ng) ? 8 + j : j - ng;
  endfunction

endpackage

// File: rtl/pmr_gpio_bit.sv
module pmr_gpio_bit
  import pmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_i,
  input  logic [1:0] route_i,
  input  logic       sci_en_i,
  input  logic       smi_en_i,
  input  logic       sci_clr_i,
  input  logic       smi_clr_i,
  output logic       sci_sts_o,
  output logic       smi_sts_o
);

  logic hit_sci, hit_smi;

  always_comb begin
    hit_sci = evt_i && (route_i == ROUTE_SCI) && sci_en_i;
    hit_smi = evt_i && (route_i == ROUTE_SMI) && smi_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_sts_o <= 1'b0;
      smi_sts_o <= 1'b0;
    end else begin
      sci_sts_o <= (sci_sts_o & ~sci_clr_i) | hit_sci;
      smi_sts_o <= (smi_sts_o & ~smi_clr_i) | hit_smi;
    end
  end

  assert_gpio_sci_qual_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sci_sts_o) |-> ($past(route_i) == ROUTE_SCI) && $past(sci_en_i) && $past(evt_i));

  assert_gpio_smi_qual_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_sts_o) |-> ($past(route_i) == ROUTE_SMI) && $past(smi_en_i) && $past(evt_i));

  assert_gpio_one_path_R2: assert property (@(posedge clk) disable iff (rst)
    !($rose(sci_sts_o) && $rose(smi_sts_o)));

endmodule

// File: rtl/pmr_fixed_sts.sv
module pmr_fixed_sts #(
  parameter int NWAKE = 4,
  localparam int FW = NWAKE + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pcie_smi_i,
  input  logic [NWAKE-1:0] wake_i,
  input  logic             usb_we_i,
  input  logic             pwrbtn_or_i,
  input  logic             release_i,
  input  logic             ssmi_req_i,
  input  logic [FW-1:0]    clr_i,
  output logic [FW-1:0]    sts_o,
  output logic             off_req_o
);

  localparam int P_PCIE = 0;
  localparam int P_WAKE = 1;
  localparam int P_USB  = NWAKE + 1;
  localparam int P_PBO  = NWAKE + 2;
  localparam int P_GBL  = NWAKE + 3;
  localparam int P_SYNC = NWAKE + 4;

  logic          usb_prev;
  logic          usb_rise;
  logic [FW-1:0] set_v;

  always_comb begin
    usb_rise                  = usb_we_i & ~usb_prev;
    set_v                     = '0;
    set_v[P_PCIE]             = pcie_smi_i;
    set_v[P_WAKE +: NWAKE]    = wake_i;
    set_v[P_USB]              = usb_rise;
    set_v[P_PBO]              = pwrbtn_or_i;
    set_v[P_GBL]              = release_i;
    set_v[P_SYNC]             = ssmi_req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o     <= '0;
      usb_prev  <= 1'b0;
      off_req_o <= 1'b0;
    end else begin
      sts_o     <= (sts_o & ~clr_i) | set_v;
      usb_prev  <= usb_we_i;
      off_req_o <= pwrbtn_or_i;
    end
  end

  assert_pcie_evt_wins_R11: assert property (@(posedge clk) disable iff (rst)
    pcie_smi_i |=> sts_o[P_PCIE]);

  assert_pbo_persist_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_o[P_PBO] && !clr_i[P_PBO]) |=> sts_o[P_PBO]);

  assert_off_req_R6: assert property (@(posedge clk) disable iff (rst)
    pwrbtn_or_i |=> off_req_o);

  assert_usb_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_o[P_USB]) |-> $past(usb_we_i));

endmodule

// File: rtl/pmr_sync_smi.sv
module pmr_sync_smi (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ack_i,
  output logic pending_o,
  output logic cpl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= 1'b0;
      cpl_o     <= 1'b0;
    end else begin
      pending_o <= req_i | (pending_o & ~ack_i);
      cpl_o     <= pending_o & ack_i;
    end
  end

  assert_cpl_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
    cpl_o |-> $past(ack_i) && $past(pending_o));

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (pending_o && !ack_i) |=> pending_o && !cpl_o);

endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
  import pmr_pkg::*;
#(
  parameter int NG    = 8,
  parameter int NWAKE = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [NG-1:0]    gpio_core_i,
  input  logic [NG-1:0]    gpio_sus_i,
  input  logic [NWAKE-1:0] wake_i,
  input  logic             pcie_smi_i,
  input  logic             usb_we_i,
  input  logic             pwrbtn_or_i,
  input  logic             ssmi_req_i,
  input  logic             ssmi_ack_i,
  output logic             sci_o,
  output logic             smi_o,
  output logic             off_req_o,
  output logic             ssmi_cpl_o
);

  localparam int NGT    = 2 * NG;
  localparam int RW     = 2 * NGT;
  localparam int FW     = NWAKE + 5;
  localparam int P_PCIE = 0;
  localparam int P_WAKE = 1;
  localparam int P_USB  = NWAKE + 1;
  localparam int P_PBO  = NWAKE + 2;
  localparam int P_GBL  = NWAKE + 3;
  localparam int P_SYNC = NWAKE + 4;
  localparam int CW     = 4 + NWAKE;

  // control
  logic             sci_en, gbl_smi_en, usb_smi_en, usb_loc_en;
  logic [NWAKE-1:0] wake_en;
  logic [NGT-1:0]   sci_en_v, smi_en_v;
  logic [RW-1:0]    route_q;

  // decoded writes
  logic w_ctrl, w_fix, w_scists, w_scien, w_smi, w_route, w_rel;
  logic [FW-1:0]  fix_clr;
  logic [NGT-1:0] sci_clr_v, smi_clr_v;

  // status
  logic [FW-1:0]  fsts;
  logic [NGT-1:0] sci_sts_v, smi_sts_v;
  logic [NGT-1:0] gpio_evt;
  logic           ssmi_pending;

  always_comb begin
    w_ctrl   = wr_en && (addr == A_CTRL);
    w_fix    = wr_en && (addr == A_FIXSTS);
    w_scists = wr_en && (addr == A_SCISTS);
    w_scien  = wr_en && (addr == A_SCIEN);
    w_smi    = wr_en && (addr == A_SMIGPIO);
    w_route  = wr_en && (addr == A_ROUTE);
    w_rel    = wr_en && (addr == A_RELEASE) && wr_data[0];
    fix_clr  = w_fix ? wr_data[FW-1:0] : '0;
    gpio_evt = {gpio_sus_i, gpio_core_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_en     <= 1'b0;
      gbl_smi_en <= 1'b0;
      usb_smi_en <= 1'b0;
      usb_loc_en <= 1'b0;
      wake_en    <= '0;
      route_q    <= '0;
    end else begin
      if (w_ctrl) begin
        sci_en     <= wr_data[0];
        gbl_smi_en <= wr_data[1];
        usb_smi_en <= wr_data[2];
        usb_loc_en <= wr_data[3];
        wake_en    <= wr_data[4 +: NWAKE];
      end
      if (w_route) route_q <= wr_data[RW-1:0];
    end
  end

  // per-GPIO enables, clears and status cells
  for (genvar j = 0; j < NGT; j++) begin : g_gpio
    localparam int SP = gpio_sts_pos(j, NG);
    localparam int EP = gpio_smien_pos(j, NG);

    always_ff @(posedge clk) begin
      if (rst) begin
        sci_en_v[j] <= 1'b0;
        smi_en_v[j] <= 1'b0;
      end else begin
        if (w_scien) sci_en_v[j] <= wr_data[SP];
        if (w_smi)   smi_en_v[j] <= wr_data[EP];
      end
    end

    always_comb begin
      sci_clr_v[j] = w_scists && wr_data[SP];
      smi_clr_v[j] = w_smi && wr_data[SP];
    end

    pmr_gpio_bit u_bit (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (gpio_evt[j]),
      .route_i   (route_q[2*j +: 2]),
      .sci_en_i  (sci_en_v[j]),
      .smi_en_i  (smi_en_v[j]),
      .sci_clr_i (sci_clr_v[j]),
      .smi_clr_i (smi_clr_v[j]),
      .sci_sts_o (sci_sts_v[j]),
      .smi_sts_o (smi_sts_v[j])
    );
  end

  pmr_fixed_sts #(.NWAKE(NWAKE)) u_fixed (
    .clk         (clk),
    .rst         (rst),
    .pcie_smi_i  (pcie_smi_i),
    .wake_i      (wake_i),
    .usb_we_i    (usb_we_i),
    .pwrbtn_or_i (pwrbtn_or_i),
    .release_i   (w_rel),
    .ssmi_req_i  (ssmi_req_i),
    .clr_i       (fix_clr),
    .sts_o       (fsts),
    .off_req_o   (off_req_o)
  );

  pmr_sync_smi u_sync (
    .clk       (clk),
    .rst       (rst),
    .req_i     (ssmi_req_i),
    .ack_i     (ssmi_ack_i),
    .pending_o (ssmi_pending),
    .cpl_o     (ssmi_cpl_o)
  );

  // interrupt aggregation
  logic sci_d, smi_d;

  always_comb begin
    sci_d = fsts[P_GBL] |
            (sci_en & ((|(fsts[P_WAKE +: NWAKE] & wake_en)) |
                       fsts[P_PBO] |
                       (|(sci_sts_v & sci_en_v))));
    smi_d = gbl_smi_en & (fsts[P_PCIE] | fsts[P_SYNC] |
                          (fsts[P_USB] & usb_loc_en & usb_smi_en) |
                          (|(smi_sts_v & smi_en_v)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_o <= 1'b0;
      smi_o <= 1'b0;
    end else begin
      sci_o <= sci_d;
      smi_o <= smi_d;
    end
  end

  // read port
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CTRL: begin
        rd_mux[0]          = sci_en;
        rd_mux[1]          = gbl_smi_en;
        rd_mux[2]          = usb_smi_en;
        rd_mux[3]          = usb_loc_en;
        rd_mux[4 +: NWAKE] = wake_en;
      end
      A_FIXSTS: rd_mux[FW-1:0] = fsts;
      A_SCISTS: for (int j = 0; j < NGT; j++) rd_mux[gpio_sts_pos(j, NG)] = sci_sts_v[j];
      A_SCIEN:  for (int j = 0; j < NGT; j++) rd_mux[gpio_sts_pos(j, NG)] = sci_en_v[j];
      A_SMIGPIO: for (int j = 0; j < NGT; j++) begin
        rd_mux[gpio_sts_pos(j, NG)]   = smi_sts_v[j];
        rd_mux[gpio_smien_pos(j, NG)] = smi_en_v[j];
      end
      A_ROUTE: rd_mux[RW-1:0] = route_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_smi_gbl_gate_R10: assert property (@(posedge clk) disable iff (rst)
    smi_o |-> $past(gbl_smi_en));

  assert_release_forces_sci_R5: assert property (@(posedge clk) disable iff (rst)
    fsts[P_GBL] |=> sci_o);

  assert_pcie_smi_no_local_en_R9: assert property (@(posedge clk) disable iff (rst)
    (fsts[P_PCIE] && gbl_smi_en) |=> smi_o);

  assert_sync_sts_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
    ssmi_pending |-> fsts[P_SYNC] || $past(fix_clr[P_SYNC]));

  assert_sci_needs_cause_R4: assert property (@(posedge clk) disable iff (rst)
    sci_o |-> $past(fsts[P_GBL]) || $past(sci_en));

endmodule

// File: tb/tb_pm_event_router.sv
module tb_pm_event_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  gpio_core_i = '0, gpio_sus_i = '0;
  logic [3:0]  wake_i = '0;
  logic        pcie_smi_i = 0, usb_we_i = 0, pwrbtn_or_i = 0, ssmi_req_i = 0, ssmi_ack_i = 0;
  logic        sci_o, smi_o, off_req_o, ssmi_cpl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pm_event_router dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .gpio_core_i(gpio_core_i),
    .gpio_sus_i(gpio_sus_i), .wake_i(wake_i), .pcie_smi_i(pcie_smi_i),
    .usb_we_i(usb_we_i), .pwrbtn_or_i(pwrbtn_or_i), .ssmi_req_i(ssmi_req_i),
    .ssmi_ack_i(ssmi_ack_i), .sci_o(sci_o), .smi_o(smi_o),
    .off_req_o(off_req_o), .ssmi_cpl_o(ssmi_cpl_o)
  );

  localparam logic [31:0] C_SCI = 32'h1, C_GBL = 32'h2, C_USBSMI = 32'h4, C_USBLOC = 32'h8;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // kind: 0 core gpio, 1 sus gpio, 2 wake, 3 pcie smi, 4 power button, 5 sync req, 6 sync ack
  task automatic pulse(input int kind, input int idx);
    @(negedge clk);
    case (kind)
      0: gpio_core_i[idx] = 1'b1;
      1: gpio_sus_i[idx]  = 1'b1;
      2: wake_i[idx]      = 1'b1;
      3: pcie_smi_i       = 1'b1;
      4: pwrbtn_or_i      = 1'b1;
      5: ssmi_req_i       = 1'b1;
      default: ssmi_ack_i = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    gpio_core_i = '0; gpio_sus_i = '0; wake_i = '0;
    pcie_smi_i = 0; pwrbtn_or_i = 0; ssmi_req_i = 0; ssmi_ack_i = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    chk("R12 sci_o", {31'b0, sci_o}, 0);
    chk("R12 smi_o", {31'b0, smi_o}, 0);
    chk("R12 off_req_o", {31'b0, off_req_o}, 0);
    chk("R12 ssmi_cpl_o", {31'b0, ssmi_cpl_o}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R12 reg %0d", a), v, 0);
    end
  endtask

  task automatic t_wake();
    logic [31:0] v;
    do_reset();
    pulse(2, 2);
    rd(3'd1, v);
    chk("R1 wake2 latched with enables off", v, 32'h8);
    settle();
    chk("R4 no sci without enables", {31'b0, sci_o}, 0);
    wr(3'd0, C_SCI);
    settle();
    chk("R4 no sci with wake_en off", {31'b0, sci_o}, 0);
    wr(3'd0, C_SCI | (32'h1 << 6));
    settle();
    chk("R13 R4 sci after wake_en", {31'b0, sci_o}, 1);
    wr(3'd1, 32'h8);
    settle();
    chk("R11 sci drops after clear", {31'b0, sci_o}, 0);
    rd(3'd1, v);
    chk("R11 wake status cleared", v, 0);
  endtask

  task automatic t_gpio();
    logic [31:0] v;
    do_reset();
    wr(3'd0, C_SCI | C_GBL);
    // core1 -> SCI, sus0 -> SCI, core3 -> SMI, sus2 -> SMI, core5 none, core6 reserved
    wr(3'd5, (32'h2 << 2) | (32'h2 << 16) | (32'h1 << 6) | (32'h1 << 20) | (32'h3 << 12));
    wr(3'd3, 32'h1 << 25);                  // only core1 SCI enabled
    pulse(0, 1); pulse(1, 0);
    rd(3'd2, v);
    chk("R2 R3 SCI gpio status only enabled core1", v, 32'h1 << 25);
    settle();
    chk("R2 sci from gpio", {31'b0, sci_o}, 1);
    wr(3'd2, 32'h1 << 25);
    wr(3'd4, (32'h1 << 11) | (32'h1 << 2)); // SMI en core3, sus2
    pulse(0, 3); pulse(1, 2); pulse(0, 5); pulse(0, 6);
    rd(3'd4, v);
    chk("R3 SMI gpio layout", v, (32'h1 << 27) | (32'h1 << 18) | (32'h1 << 11) | (32'h1 << 2));
    rd(3'd2, v);
    chk("R2 SMI/none/reserved routes leave SCI status clear", v, 0);
    settle();
    chk("R10 smi from gpio", {31'b0, smi_o}, 1);
    wr(3'd4, (32'h1 << 27) | (32'h1 << 18));
    pulse(0, 1);                            // enabled core1, but route to SCI with en: set
    wr(3'd5, 32'h1 << 2);                   // core1 now SMI route, SMI en off
    wr(3'd2, 32'h1 << 25);
    pulse(0, 1);
    rd(3'd4, v);
    chk("R2 SMI route without SMI enable latches nothing", v, 0);
    rd(3'd2, v);
    chk("R2 SMI route does not latch SCI path", v, 0);
  endtask

  task automatic t_release();
    logic [31:0] v;
    do_reset();
    wr(3'd6, 32'h1);
    rd(3'd1, v);
    chk("R5 release status bit7", v, 32'h80);
    chk("R5 sci forced with sci_en 0", {31'b0, sci_o}, 1);
    wr(3'd1, 32'h80);
    settle();
    chk("R5 sci drops after release clear", {31'b0, sci_o}, 0);
  endtask

  task automatic t_pwrbtn();
    logic [31:0] v;
    do_reset();
    pulse(4, 0);
    chk("R6 off request pulse", {31'b0, off_req_o}, 1);
    settle();
    chk("R6 off request one cycle", {31'b0, off_req_o}, 0);
    chk("R6 no sci while disabled", {31'b0, sci_o}, 0);
    repeat (5) settle();
    rd(3'd1, v);
    chk("R6 override status persists", v, 32'h40);
    wr(3'd0, C_SCI);
    settle();
    chk("R6 sci once enabled", {31'b0, sci_o}, 1);
    do_reset();
    pulse(4, 0);
    wr(3'd1, 32'h40);
    wr(3'd0, C_SCI);
    settle();
    chk("R6 no sci when cleared first", {31'b0, sci_o}, 0);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    do_reset();
    wr(3'd0, C_GBL);
    pulse(5, 0);
    for (int i = 0; i < 5; i++) begin
      chk("R7 completion withheld", {31'b0, ssmi_cpl_o}, 0);
      settle();
    end
    chk("R7 sync smi raises smi", {31'b0, smi_o}, 1);
    rd(3'd1, v);
    chk("R7 sync status bit8", v, 32'h100);
    pulse(6, 0);
    chk("R7 completion after ack", {31'b0, ssmi_cpl_o}, 1);
    settle();
    chk("R7 completion one cycle", {31'b0, ssmi_cpl_o}, 0);
    pulse(6, 0);
    chk("R7 stray ack ignored", {31'b0, ssmi_cpl_o}, 0);
  endtask

  task automatic t_usb();
    logic [31:0] v;
    do_reset();
    wr(3'd0, C_GBL);
    @(negedge clk); usb_we_i = 1'b1;
    settle();
    rd(3'd1, v);
    chk("R8 R1 usb status latched with enables off", v, 32'h20);
    chk("R8 no smi without enables", {31'b0, smi_o}, 0);
    wr(3'd0, C_GBL | C_USBLOC);
    settle();
    chk("R8 no smi with only local enable", {31'b0, smi_o}, 0);
    wr(3'd0, C_GBL | C_USBLOC | C_USBSMI);
    settle();
    chk("R8 smi with both enables", {31'b0, smi_o}, 1);
    wr(3'd1, 32'h20);
    repeat (3) settle();
    rd(3'd1, v);
    chk("R8 held level does not relatch", v, 0);
    chk("R8 smi drops", {31'b0, smi_o}, 0);
    @(negedge clk); usb_we_i = 1'b0;
  endtask

  task automatic t_pcie_smi();
    logic [31:0] v;
    do_reset();
    pulse(3, 0);
    rd(3'd1, v);
    chk("R9 pcie smi status bit0", v, 32'h1);
    chk("R10 no smi with global enable off", {31'b0, smi_o}, 0);
    wr(3'd0, C_GBL);
    settle();
    chk("R9 R10 smi with only global enable", {31'b0, smi_o}, 1);
    wr(3'd0, 32'h0);
    settle();
    chk("R10 smi drops when global disabled", {31'b0, smi_o}, 0);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd1; wr_data = 32'h2; wake_i = 4'h1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wake_i = '0;
    rd(3'd1, v);
    chk("R11 event wins over same-cycle clear", v, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, v);
    chk("R11 later clear works", v, 0);
  endtask

  initial begin
    t_reset_state();
    t_wake();
    t_gpio();
    t_release();
    t_pwrbtn();
    t_sync();
    t_usb();
    t_pcie_smi();
    t_clear_race();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule